// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the programmable feedback divider of a frequency synthesizer. A small prescaler divides the incoming cycles by either P or P+1. Two slower counters are stepped once per prescaler wrap. The swallow counter sets how many prescaler wraps use the longer modulus. The main counter sets how many wraps make one output period. The total division is N = P·B + A input cycles per output pulse. This gives single-cycle resolution of N from a prescaler that only knows two moduli.

Everything runs in one clock domain. Each clock cycle with `ce_in` high counts as one input cycle. The prescaler advances only on those cycles, and the two counters advance only when the prescaler wraps. The swallow value A and the main value B are sampled only at the end of an output period, so every period uses one consistent N. A pair with A greater than B, or with B equal to zero, is refused: the flag `cfg_err` rises and the previous pair stays in use. P is a parameter, normally 8 or 16.

Top module: `pulse_swallow_div`

## Requirements
- R1: Between two output pulses, exactly N = P·B + A cycles with `ce_in` high are consumed, where A and B are the values in use for that period.
- R2: `mod_sel` = 1 means the prescaler divides by P+1, and `mod_sel` = 0 means it divides by P. In each period, `mod_sel` is 1 during the first A·(P+1) enabled input cycles and 0 during the remaining (B−A)·P cycles.
- R3: With the defaults P = 8, A = 2, B = 11, the divider produces one pulse every 90 enabled input cycles, and 18 of those cycles have `mod_sel` = 1.
- R4: Cycles with `ce_in` low do not advance the divider and never produce an output pulse. N counts only enabled cycles, whatever pattern of gaps is applied.
- R5: `div_pulse` is registered and lasts one clock cycle. It is high in the cycle right after the clock edge that consumes the Nth enabled input cycle.
- R6: `swallow_in` and `main_in` are sampled only on the edge that ends a period. A change made during a period takes effect in the period that follows the next pulse.
- R7: If a period ends while `swallow_in` > `main_in` or `main_in` = 0, then `cfg_err` becomes 1 on that edge and the previous A and B remain in use. At the next period end with a valid pair, `cfg_err` returns to 0 and the new pair is taken.
- R8: At the start of every period, `mod_sel` returns to 1 when the new A is nonzero. With A = 0, every period divides by exactly P·B and `mod_sel` stays 0.
- R9: Synchronous active-high reset clears `div_pulse` and `cfg_err`, loads A = 2 and B = 11, and restarts the count, which leaves `mod_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | Input-cycle enable; each high cycle is one input cycle |
| swallow_in | input | A_W (5) | Requested swallow count A |
| main_in | input | B_W (13) | Requested main count B |
| div_pulse | output | 1 | One-cycle pulse once per N enabled input cycles |
| mod_sel | output | 1 | Present prescaler modulus: 1 = P+1, 0 = P |
| cfg_err | output | 1 | Last sampled A/B pair was refused |

## Verification
The output pulse is due on the same edge that consumes the Nth enabled input cycle. The bench drives inputs on the falling edge and samples `div_pulse` at the next falling edge, so each enabled cycle it applies is paired with the pulse it may cause. A new A/B pair and `cfg_err` take effect on the edge that ends the period. For that reason the bench changes the values just after one pulse, expects the old N for the next period, and expects the new N only in the period after that. `mod_sel` is sampled before each enabled edge, which shows the modulus in force for that input cycle.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    MOD_P  = 1'b0,
    MOD_P1 = 1'b1
  } mod_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int P = 8,
  localparam int PC_W = $clog2(P + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  mod_e            mode,
  output logic            tick,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] last_state;

  // P+1 states when the long modulus is selected, P states otherwise
  assign last_state = (mode == MOD_P1) ? PC_W'(P) : PC_W'(P - 1);
  assign tick       = ce && (pc == last_state);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (ce) begin
      if (tick) pc <= '0;
      else      pc <= pc + PC_W'(1);
    end
  end
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
  import psd_pkg::*;
#(
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           period_end,
  input  logic [A_W-1:0] cur_a,
  output mod_e           mode
);
  logic [A_W-1:0] ac;

  assign mode = (ac < cur_a) ? MOD_P1 : MOD_P;

  always_ff @(posedge clk) begin
    if (rst) begin
      ac <= '0;
    end else if (tick) begin
      if (period_end)        ac <= '0;
      else if (ac < cur_a)   ac <= ac + A_W'(1);
    end
  end
endmodule

// File: rtl/psd_main_ctr.sv
module psd_main_ctr #(
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [B_W-1:0] cur_b,
  output logic           last
);
  logic [B_W-1:0] bc;

  assign last = (bc == cur_b - B_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bc <= '0;
    end else if (tick) begin
      if (last) bc <= '0;
      else      bc <= bc + B_W'(1);
    end
  end
endmodule

// File: rtl/psd_cfg.sv
module psd_cfg #(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int DEF_A = 2,
  parameter int DEF_B = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           boundary,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [A_W-1:0] cur_a,
  output logic [B_W-1:0] cur_b,
  output logic           err
);
  logic pair_ok;

  assign pair_ok = (b_in != '0) && (B_W'(a_in) <= b_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_a <= A_W'(DEF_A);
      cur_b <= B_W'(DEF_B);
      err   <= 1'b0;
    end else if (boundary) begin
      if (pair_ok) begin
        cur_a <= a_in;
        cur_b <= b_in;
        err   <= 1'b0;
      end else begin
        err   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int P     = 8,
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int DEF_A = 2,
  parameter int DEF_B = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce_in,
  input  logic [A_W-1:0] swallow_in,
  input  logic [B_W-1:0] main_in,
  output logic           div_pulse,
  output logic           mod_sel,
  output logic           cfg_err
);
  localparam int PC_W = $clog2(P + 1);

  logic [A_W-1:0]  cur_a;
  logic [B_W-1:0]  cur_b;
  logic [PC_W-1:0] pc;
  logic            tick;
  logic            last;
  logic            period_end;
  mod_e            mode;

  assign period_end = tick && last;
  assign mod_sel    = (mode == MOD_P1);

  psd_cfg #(.A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_cfg (
    .clk(clk), .rst(rst), .boundary(period_end),
    .a_in(swallow_in), .b_in(main_in),
    .cur_a(cur_a), .cur_b(cur_b), .err(cfg_err)
  );

  psd_prescaler #(.P(P)) u_pre (
    .clk(clk), .rst(rst), .ce(ce_in), .mode(mode), .tick(tick), .pc(pc)
  );

  psd_swallow_ctr #(.A_W(A_W)) u_swl (
    .clk(clk), .rst(rst), .tick(tick), .period_end(period_end),
    .cur_a(cur_a), .mode(mode)
  );

  psd_main_ctr #(.B_W(B_W)) u_main (
    .clk(clk), .rst(rst), .tick(tick), .cur_b(cur_b), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= period_end;
  end
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int P   = 8,
  parameter int A_W = 5,
  parameter int B_W = 13,
  localparam int PC_W = $clog2(P + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            ce_in,
  input logic [A_W-1:0]  swallow_in,
  input logic [B_W-1:0]  main_in,
  input logic            div_pulse,
  input logic            mod_sel,
  input logic            cfg_err,
  input logic            period_end,
  input logic [A_W-1:0]  cur_a,
  input logic [B_W-1:0]  cur_b,
  input logic [PC_W-1:0] pc
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R5
  AST_PULSE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !ce_in |=> !div_pulse); // R4
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(cur_a) && $stable(cur_b))); // R6
  AST_BAD_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (period_end && ((B_W'(swallow_in) > main_in) || (main_in == '0)))
      |=> (cfg_err && $stable(cur_a) && $stable(cur_b))); // R7
  AST_MOD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && (cur_a != '0)) |-> mod_sel); // R8
  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst)
    pc <= PC_W'(P)); // R2
endmodule

bind pulse_swallow_div psd_checker #(.P(P), .A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst(rst), .ce_in(ce_in), .swallow_in(swallow_in),
  .main_in(main_in), .div_pulse(div_pulse), .mod_sel(mod_sel),
  .cfg_err(cfg_err), .period_end(period_end), .cur_a(cur_a),
  .cur_b(cur_b), .pc(pc)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;
  localparam int P = 8;
  localparam int A_W = 5;
  localparam int B_W = 13;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ce_in = 1'b0;
  logic [A_W-1:0] swallow_in = 5'd2;
  logic [B_W-1:0] main_in = 13'd11;
  logic           div_pulse;
  logic           mod_sel;
  logic           cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  pulse_swallow_div #(.P(P), .A_W(A_W), .B_W(B_W)) u_pulse_swallow_div (
    .clk(clk), .rst(rst), .ce_in(ce_in), .swallow_in(swallow_in),
    .main_in(main_in), .div_pulse(div_pulse), .mod_sel(mod_sel),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests = n_tests + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive enabled cycles (every cycle, or every other one when gap is set)
  // until a pulse appears; return enabled-cycle count and high-modulus count.
  task automatic run_period(input bit gap, output int n_ce, output int n_hi);
    bit tog = 1'b1;
    bit done = 1'b0;
    int guard = 0;
    n_ce = 0;
    n_hi = 0;
    while (!done && guard < 5000) begin
      bit drive = gap ? tog : 1'b1;
      tog = ~tog;
      guard++;
      if (drive && mod_sel) n_hi++;
      ce_in = drive;
      @(posedge clk);
      @(negedge clk);
      if (drive) n_ce++;
      if (div_pulse) begin
        done = 1'b1;
        if (!drive) chk("R4 pulse on idle cycle", 1, 0);
      end
    end
    ce_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R5 pulse width", int'(div_pulse), 0);
  endtask

  task automatic set_pair(input int a, input int b);
    swallow_in = A_W'(a);
    main_in    = B_W'(b);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 pulse after reset", int'(div_pulse), 0);
    chk("R9 cfg_err after reset", int'(cfg_err), 0);
    chk("R9 mod_sel after reset", int'(mod_sel), 1);
  endtask

  task automatic t_default();
    int n, h;
    run_period(1'b0, n, h);
    chk("R3 first period", n, 90);
    chk("R2 high cycles default", h, 18);
    run_period(1'b0, n, h);
    chk("R3 second period", n, 90);
    chk("R1 high cycles repeat", h, 18);
  endtask

  task automatic t_reload();
    int n, h;
    set_pair(5, 20);
    run_period(1'b0, n, h);
    chk("R6 old N kept", n, 90);
    run_period(1'b0, n, h);
    chk("R1 N for A5 B20", n, 165);
    chk("R2 high cycles A5", h, 45);
  endtask

  task automatic t_gap_zero_swallow();
    int n, h;
    set_pair(0, 3);
    run_period(1'b1, n, h);
    chk("R4 gapped old N", n, 165);
    run_period(1'b1, n, h);
    chk("R8 A0 gapped N", n, 24);
    chk("R8 A0 high cycles", h, 0);
    chk("R8 A0 mod_sel low", int'(mod_sel), 0);
  endtask

  task automatic t_a_equals_b();
    int n, h;
    set_pair(4, 4);
    run_period(1'b0, n, h);
    chk("R6 old N before A=B", n, 24);
    chk("R8 mod_sel restart", int'(mod_sel), 1);
    run_period(1'b0, n, h);
    chk("R1 N for A4 B4", n, 36);
    chk("R2 all long modulus", h, 36);
  endtask

  task automatic t_bad_pair();
    int n, h;
    set_pair(9, 3);
    run_period(1'b0, n, h);
    chk("R7 period before refusal", n, 36);
    chk("R7 cfg_err set", int'(cfg_err), 1);
    run_period(1'b0, n, h);
    chk("R7 old N held", n, 36);
    chk("R7 cfg_err stays", int'(cfg_err), 1);
    set_pair(0, 0);
    run_period(1'b0, n, h);
    chk("R7 B0 held N", n, 36);
    chk("R7 B0 flagged", int'(cfg_err), 1);
    set_pair(1, 1);
    run_period(1'b0, n, h);
    chk("R7 last held period", n, 36);
    chk("R7 cfg_err cleared", int'(cfg_err), 0);
    run_period(1'b0, n, h);
    chk("R1 N for A1 B1", n, 9);
    chk("R2 high cycles A1", h, 9);
  endtask

  initial begin
    t_reset();
    t_default();
    t_reload();
    t_gap_zero_swallow();
    t_a_equals_b();
    t_bad_pair();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule